// File: doc/BRIEF.md
# Double-Edge Strobe Burst Transmitter

This block is the sending end of a source-synchronous burst on a 16-bit parallel bus. Words arrive on a valid/ready port. For each word the block first places the word on the data bus and then inverts a single strobe line. Every strobe inversion, rising or falling, marks exactly one word. The receiver latches on both polarities.

Three timing windows are counted in system clocks. Setup is the time from a data change to the strobe edge that marks it. Hold is the time from a strobe edge to the next data change. Cycle is the minimum time between any two strobe edges. All three are sampled from configuration inputs when a burst starts, together with the word count. A pause input keeps the bus frozen between words. A one-cycle done pulse reports the end of the burst once the last hold window has expired.

Top module: `ddr_strobe_tx`

## Requirements
- R1: After reset, `data_o` is 0, `strobe_o` is 0, and `in_ready_o`, `busy_o` and `done_o` are all 0.
- R2: Each accepted word is driven on `data_o` before the strobe inverts. The value on `data_o` at each strobe edge, rising or falling, equals the accepted words in the order they were accepted.
- R3: A strobe edge comes no sooner than `setup_i` clocks after the last change of `data_o`. The first word of a burst gets exactly that setup, provided the previous edge is at least `cycle_i` clocks old.
- R4: `data_o` does not change sooner than `hold_i` clocks after a strobe edge. When input is always valid, the next word appears exactly `hold_i` clocks after the edge.
- R5: Any two consecutive strobe edges are at least `cycle_i` clocks apart. When input is always valid, the spacing is exactly max(`cycle_i`, `setup_i`+`hold_i`).
- R6: Two edges of the same polarity are at least twice the cycle time apart.
- R7: A timing value of 0 behaves as 1. Timing values and the word count are captured only when a burst starts.
- R8: While `pause_i` is high, no word is accepted. Once the hold time of the current edge has expired, `strobe_o` keeps its level and `data_o` keeps its value until `pause_i` falls.
- R9: A burst of N words makes exactly N strobe edges. `done_o` is high for exactly one clock, `hold_i` clocks after the final edge, and `busy_o` is low afterwards.
- R10: A burst started with a word count of 0 makes no strobe edge and still pulses `done_o` once.
- R11: `start_i` is ignored while `busy_o` is high. The burst length stays as it was first loaded.
- R12: `in_ready_o` is high only while a burst is running, the hold time has expired and words remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a burst; loads word count and timing |
| word_cnt_i | input | 16 | Number of words in the burst |
| setup_i | input | 8 | Setup clocks, data change to strobe edge |
| hold_i | input | 8 | Hold clocks, strobe edge to data change |
| cycle_i | input | 8 | Minimum clocks between strobe edges |
| pause_i | input | 1 | Hold off the next word |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 16 | Input word |
| in_ready_o | output | 1 | Block takes the input word this clock |
| data_o | output | 16 | Data bus |
| strobe_o | output | 1 | Double-edge strobe |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock end-of-burst pulse |

## Verification
The hardest case to reach is a pause that lands between words. It must arrive after an edge but before that edge's hold window expires, so the word in flight completes and the next one is blocked. The stimulus watches the strobe and raises pause on the same half-cycle that it sees the second edge, which is always inside the hold window. In the same burst, a second start with a larger count is issued after the first edge. The bench then measures every setup, hold and edge spacing in clock cycles. For the vector table these must be exact; for the paused run they need only meet the minimum.

// File: rtl/ddr_tx_pkg.sv
package ddr_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SETUP = 2'd2
  } tx_state_e;

  localparam int unsigned N_TIMERS = 3;
  localparam int unsigned T_SETUP  = 0;
  localparam int unsigned T_HOLD   = 1;
  localparam int unsigned T_GAP    = 2;
endpackage

// File: rtl/ddr_tx_timer.sv
module ddr_tx_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT = '1;

  // restart at 1 so the count equals clocks elapsed at the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= SAT;
    else if (clr_i)        cnt_o <= W'(1);
    else if (cnt_o != SAT) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ddr_tx_cfg.sv
module ddr_tx_cfg #(
  parameter int unsigned TW = 8,
  parameter int unsigned NF = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NF-1:0][TW-1:0] raw_i,
  output logic [NF-1:0][TW-1:0] q_o
);
  for (genvar g = 0; g < NF; g++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[g] <= TW'(1);
      else if (load_i) q_o[g] <= (raw_i[g] == '0) ? TW'(1) : raw_i[g];
    end
  end
endmodule

// File: rtl/ddr_strobe_tx.sv
module ddr_strobe_tx
  import ddr_tx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] word_cnt_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] hold_i,
  input  logic [TW-1:0] cycle_i,
  input  logic          pause_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic [DW-1:0] data_o,
  output logic          strobe_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [TW-1:0] AGE_SAT = '1;

  tx_state_e                         state_q;
  logic [CW-1:0]                     remain_q;
  logic [N_TIMERS-1:0]               tmr_clr;
  logic [N_TIMERS-1:0][TW-1:0]       tmr_cnt;
  logic [N_TIMERS-1:0][TW-1:0]       cfg_raw;
  logic [N_TIMERS-1:0][TW-1:0]       cfg_q;
  logic                              load, fire, tog, fin, hold_ok;
  logic [TW-1:0]                     setup_q, hold_q, cycle_q;

  assign cfg_raw[T_SETUP] = setup_i;
  assign cfg_raw[T_HOLD]  = hold_i;
  assign cfg_raw[T_GAP]   = cycle_i;
  assign setup_q = cfg_q[T_SETUP];
  assign hold_q  = cfg_q[T_HOLD];
  assign cycle_q = cfg_q[T_GAP];

  ddr_tx_cfg #(.TW(TW), .NF(N_TIMERS)) cfg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .raw_i  (cfg_raw),
    .q_o    (cfg_q)
  );

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    ddr_tx_timer #(.W(TW)) tmr_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (tmr_clr[g]),
      .cnt_o  (tmr_cnt[g])
    );
  end

  assign load    = (state_q == ST_IDLE) && start_i;
  assign hold_ok = tmr_cnt[T_HOLD] >= hold_q;
  assign in_ready_o = (state_q == ST_HOLD) && hold_ok && !pause_i && (remain_q != '0);
  assign fire    = in_ready_o && in_valid_i;
  assign tog     = (state_q == ST_SETUP) && (tmr_cnt[T_SETUP] >= setup_q)
                   && (tmr_cnt[T_GAP] >= cycle_q);
  assign fin     = (state_q == ST_HOLD) && hold_ok && (remain_q == '0);

  assign tmr_clr[T_SETUP] = fire;
  assign tmr_clr[T_HOLD]  = tog;
  assign tmr_clr[T_GAP]   = tog;

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      data_o   <= '0;
      strobe_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= fin;
      unique case (state_q)
        ST_IDLE: if (load) begin
          remain_q <= word_cnt_i;
          state_q  <= ST_HOLD;
        end
        ST_HOLD: begin
          if (fire) begin
            data_o   <= in_data_i;
            remain_q <= remain_q - 1'b1;
            state_q  <= ST_SETUP;
          end else if (fin) begin
            state_q <= ST_IDLE;
          end
        end
        ST_SETUP: if (tog) begin
          strobe_o <= ~strobe_o;
          state_q  <= ST_HOLD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // port-side timing observers for the checks below
  logic          obs_strb_q;
  logic [DW-1:0] obs_data_q;
  logic [TW-1:0] obs_dage, obs_eage, obs_prev_gap;
  logic          obs_edge, obs_dchg;

  assign obs_edge = strobe_o != obs_strb_q;
  assign obs_dchg = data_o != obs_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obs_strb_q   <= 1'b0;
      obs_data_q   <= '0;
      obs_dage     <= AGE_SAT;
      obs_eage     <= AGE_SAT;
      obs_prev_gap <= AGE_SAT;
    end else begin
      obs_strb_q <= strobe_o;
      obs_data_q <= data_o;
      obs_dage   <= obs_dchg ? TW'(1) : (obs_dage == AGE_SAT ? AGE_SAT : obs_dage + 1'b1);
      obs_eage   <= obs_edge ? TW'(1) : (obs_eage == AGE_SAT ? AGE_SAT : obs_eage + 1'b1);
      if (obs_edge) obs_prev_gap <= obs_eage;
    end
  end

  // R3
  setup_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obs_edge |-> (!obs_dchg && obs_dage >= setup_q));
  // R4
  hold_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obs_dchg |-> obs_eage >= hold_q);
  // R5
  edge_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obs_edge |-> obs_eage >= cycle_q);
  // R6
  same_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    obs_edge |-> ({1'b0, obs_eage} + {1'b0, obs_prev_gap}) >= {cycle_q, 1'b0});
  // R8
  pause_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> !obs_dchg);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (obs_eage >= hold_q && !busy_o));
endmodule

// File: tb/ddr_strobe_tx_tb_top.sv
module ddr_strobe_tx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] word_cnt_i = '0;
  logic [7:0]  setup_i = '0, hold_i = '0, cycle_i = '0;
  logic        pause_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        in_ready_o, strobe_o, busy_o, done_o;
  logic [15:0] data_o;

  always #10 clk_i = ~clk_i;

  ddr_strobe_tx dut_i (.*);

  // {setup, hold, cycle, words}
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 8'd1, 8'd1,  8'd4},
    {8'd2, 8'd3, 8'd1,  8'd5},
    {8'd1, 8'd1, 8'd6,  8'd6},
    {8'd3, 8'd2, 8'd10, 8'd3},
    {8'd0, 8'd0, 8'd0,  8'd4},
    {8'd4, 8'd1, 8'd5,  8'd7},
    {8'd2, 8'd2, 8'd4,  8'd2}
  };

  int total = 0, bad = 0;
  int cyc = 0;
  logic strb_p = 1'b0;
  logic [15:0] data_p = '0;
  int t_dchg = 0, t_edge = 0, t_edge_prev = 0;
  int n_edges = 0, n_done = 0, t_done = 0;
  bit mon_en = 0, relax = 0, feeding = 0, fire_q = 0, ended = 0;
  int exp_setup_first = 0, exp_setup = 0, exp_hold = 0, exp_gap = 0, exp_cyc = 0;
  int widx = 0, nw = 0;
  logic [15:0] exp_words [16];

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  function automatic void chk_t(input string req, input int act, input int exp);
    chk(relax ? (act >= exp) : (act == exp), req, act, exp);
  endfunction

  always @(posedge clk_i) fire_q <= in_valid_i && in_ready_o;

  always @(negedge clk_i) begin
    cyc++;
    if (data_o != data_p) begin
      if (mon_en && n_edges > 0) chk_t("R4 hold", cyc - t_edge, exp_hold);
      t_dchg = cyc;
    end
    if (strobe_o != strb_p) begin
      if (mon_en) begin
        chk(n_edges < 16 && data_o == exp_words[n_edges & 15], "R2 word", int'(data_o),
            int'(exp_words[n_edges & 15]));
        chk_t("R3 setup", cyc - t_dchg, (n_edges == 0) ? exp_setup_first : exp_setup);
        if (n_edges > 0) chk_t("R5 spacing", cyc - t_edge, exp_gap);
        if (n_edges > 1) chk(cyc - t_edge_prev >= 2 * exp_cyc, "R6 same polarity",
                             cyc - t_edge_prev, 2 * exp_cyc);
      end
      t_edge_prev = t_edge;
      t_edge = cyc;
      n_edges++;
    end
    if (done_o) begin
      n_done++;
      t_done = cyc;
    end
    data_p = data_o;
    strb_p = strobe_o;
    if (fire_q) widx++;
    in_valid_i = feeding && (widx < nw);
    in_data_i  = exp_words[widx & 15];
    if (cyc > 150000 && !ended) begin
      ended = 1;
      chk(0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic arm(input int s, input int h, input int c, input int n, input int base);
    int se = eff(s), he = eff(h), ce = eff(c);
    exp_hold = he;
    exp_cyc = ce;
    exp_gap = (ce > se + he) ? ce : se + he;
    exp_setup_first = se;
    exp_setup = exp_gap - he;
    for (int i = 0; i < 16; i++) exp_words[i] = 16'(base * 16'h1100 + i * 16'h0123 + 16'h0001);
    n_edges = 0; n_done = 0; widx = 0; nw = n; mon_en = 1;
    setup_i = 8'(s); hold_i = 8'(h); cycle_i = 8'(c); word_cnt_i = 16'(n);
    feeding = 1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_burst(input int n, input int h);
    int guard = 0;
    while (n_done == 0 && guard < 5000) begin
      @(negedge clk_i);
      guard++;
    end
    repeat (5) @(negedge clk_i);
    chk(n_edges == n, "R9 edge count", n_edges, n);
    chk(n_done == 1, "R9 done pulses", n_done, 1);
    if (n > 0) chk(t_done - t_edge == eff(h), "R9 done delay", t_done - t_edge, eff(h));
    chk(busy_o == 1'b0, "R9 busy after done", int'(busy_o), 0);
    chk(in_ready_o == 1'b0, "R12 ready idle", int'(in_ready_o), 0);
    feeding = 0; mon_en = 0; relax = 0;
    repeat (300) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(data_o == 16'h0, "R1 data", int'(data_o), 0);
    chk(strobe_o == 1'b0, "R1 strobe", int'(strobe_o), 0);
    chk(in_ready_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1 flags",
        int'({in_ready_o, busy_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (300) @(negedge clk_i);
    chk(in_ready_o == 1'b0, "R12 ready before start", int'(in_ready_o), 0);

    // table walk: R2..R7, R9 (entry 4 has all-zero timing for R7)
    for (int v = 0; v < NV; v++) begin
      arm(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), v + 1);
      finish_burst(int'(VEC[v][7:0]), int'(VEC[v][23:16]));
    end

    // R10: zero-length burst
    arm(2, 2, 2, 0, 9);
    finish_burst(0, 2);

    // R8 + R11: restart attempt mid-burst, then pause between words
    begin
      int guard = 0;
      int e0;
      logic [15:0] d0;
      logic s0;
      arm(2, 2, 3, 6, 11);
      while (n_edges < 1 && guard < 1000) begin @(negedge clk_i); guard++; end
      word_cnt_i = 16'd9;
      setup_i = 8'd7;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      while (n_edges < 2 && guard < 2000) begin @(negedge clk_i); guard++; end
      pause_i = 1'b1;
      relax = 1;
      repeat (3) @(negedge clk_i);
      e0 = n_edges; d0 = data_o; s0 = strobe_o;
      repeat (20) @(negedge clk_i);
      chk(n_edges == e0, "R8 no edge in pause", n_edges, e0);
      chk(data_o == d0, "R8 data frozen", int'(data_o), int'(d0));
      chk(strobe_o == s0, "R8 strobe level kept", int'(strobe_o), int'(s0));
      chk(in_ready_o == 1'b0, "R8 ready low in pause", int'(in_ready_o), 0);
      pause_i = 1'b0;
      finish_burst(6, 2); // R11: length stays 6
    end

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule